// File: doc/BRIEF.md
# Bus Ownership Requester for Block Transfers

This block obtains and gives up ownership of a shared system data-transfer bus on behalf of a local DMA engine. When the engine wants to move data, the block raises one of four bus-request lines. Software selects that line through a configuration field. The block then waits for a grant on the daisy-chain input of the same priority level. Once the grant arrives it drives the bus-busy line, drops its request and tells the engine that the bus is its own. Grants that it has not asked for pass straight on to the next board down the chain.

Ownership ends in one of two ways. The default policy keeps the bus until the engine withdraws its transfer request. The alternative policy gives the bus up as soon as any other board raises any request line. Under either policy a data cycle that is in progress runs to completion. Bus-busy stays asserted for at least one clock after the data strobe goes inactive.

States and transitions:
- `ST_IDLE`: nothing asserted. Goes to `ST_ASK` when `dma_req` is high, and latches the level at that point.
- `ST_ASK`: the request is asserted. Goes to `ST_SEIZE` on a grant at the latched level.
- `ST_SEIZE`: busy and request are both asserted for one clock. Always goes to `ST_HOLD`.
- `ST_HOLD`: busy is asserted, the request is dropped and ownership is reported. When the release condition holds it goes to `ST_DRAIN` if the strobe is active and to `ST_TAIL` if it is not.
- `ST_DRAIN`: busy is asserted until the strobe goes inactive, then the state goes to `ST_TAIL`.
- `ST_TAIL`: busy is asserted for one final clock, then the state goes to `ST_IDLE`.

Top module: `dtb_requester`

## Requirements
- R1: While reset is asserted, `br_out` is 0, `bbsy_out` is 0 and `bus_owned` is 0, and `bg_out` equals `bg_in`.
- R2: In idle, a high `dma_req` at a clock edge makes `br_out` one-hot after that edge. The bit set is the one whose index equals `cfg_level` (bit n is level n).
- R3: With the request raised, a grant on `bg_in` at the requested bit makes `bbsy_out` high after the next edge, while `br_out` stays high for that one clock. After the following edge `br_out` is 0 and `bus_owned` is 1.
- R4: On the selected level, `bg_out` copies `bg_in` only while idle. From the raising of the request until the return to idle, that bit of `bg_out` is 0.
- R5: On the other three levels, `bg_out` always copies `bg_in`.
- R6: With `cfg_ror` = 0, activity on `br_in` has no effect on ownership. The bus is kept until `dma_req` is sampled low.
- R7: With `cfg_ror` = 1, any bit of `br_in` sampled high while the bus is owned also ends ownership.
- R8: When ownership ends, `bus_owned` falls after that edge. `bbsy_out` stays high while `ds_active` is high and for one further clock after `ds_active` is sampled low.
- R9: The level is latched when the request is raised. Changing `cfg_level` before the block returns to idle has no effect on `br_out` or on which grant bit is blocked or accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 2 | Selected request/grant level |
| cfg_ror | input | 1 | 1 selects release-on-request, 0 selects release-when-done |
| dma_req | input | 1 | DMA engine wants the bus |
| ds_active | input | 1 | A data strobe of the engine is active |
| br_in | input | 4 | Bus request lines observed from other boards (active high) |
| bg_in | input | 4 | Grant daisy-chain inputs, one per level (active high) |
| br_out | output | 4 | Bus request lines driven by this block |
| bg_out | output | 4 | Grant daisy-chain outputs to the next board |
| bbsy_out | output | 1 | Bus busy, driven while the block holds the bus |
| bus_owned | output | 1 | Tells the DMA engine it may run data cycles |

## Verification
The assertions make no assumption about the inputs. They hold for any pattern of grants, foreign requests, strobes and configuration changes, including grants that arrive while the block is not asking and strobes that rise during the final busy clock. The stimulus therefore drives all inputs from a pseudo-random generator with no constraint, and biases only their rates: `dma_req` and `cfg_level` change slowly, and the release policy flips in long stretches. This lets every state and both release paths recur many times.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ASK   = 3'd1,
        ST_SEIZE = 3'd2,
        ST_HOLD  = 3'd3,
        ST_DRAIN = 3'd4,
        ST_TAIL  = 3'd5
    } arb_state_t;
endpackage

// File: rtl/dtb_arb_fsm.sv
module dtb_arb_fsm
    import dtb_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LVL_W-1:0]      cfg_level,
    input  logic                  cfg_ror,
    input  logic                  dma_req,
    input  logic                  ds_active,
    input  logic [NUM_LEVELS-1:0] br_in,
    input  logic [NUM_LEVELS-1:0] bg_in,
    output arb_state_t            state,
    output logic [LVL_W-1:0]      lvl_q
);
    arb_state_t state_nx;
    logic       release_now;

    // Release condition: engine done, or (optional policy) a foreign request.
    always_comb begin
        release_now = !dma_req || (cfg_ror && (|br_in));
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (dma_req) state_nx = ST_ASK;
            ST_ASK:   if (bg_in[lvl_q]) state_nx = ST_SEIZE;
            ST_SEIZE: state_nx = ST_HOLD;
            ST_HOLD:  if (release_now) state_nx = ds_active ? ST_DRAIN : ST_TAIL;
            ST_DRAIN: if (!ds_active) state_nx = ST_TAIL;
            ST_TAIL:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lvl_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && dma_req) lvl_q <= cfg_level;
        end
    end
endmodule

// File: rtl/dtb_out_decode.sv
module dtb_out_decode
    import dtb_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  arb_state_t            state,
    input  logic [LVL_W-1:0]      lvl_q,
    output logic [NUM_LEVELS-1:0] br_out,
    output logic                  bbsy_out,
    output logic                  bus_owned
);
    logic asking;

    always_comb begin
        asking    = 1'b0;
        bbsy_out  = 1'b0;
        bus_owned = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ASK:   asking = 1'b1;
            ST_SEIZE: begin asking = 1'b1; bbsy_out = 1'b1; end
            ST_HOLD:  begin bbsy_out = 1'b1; bus_owned = 1'b1; end
            ST_DRAIN: bbsy_out = 1'b1;
            ST_TAIL:  bbsy_out = 1'b1;
            default:  ;
        endcase
    end

    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_br
        assign br_out[i] = asking && (lvl_q == LVL_W'(i));
    end
endmodule

// File: rtl/dtb_grant_chain.sv
module dtb_grant_chain #(
    parameter int NUM_LEVELS = 4,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  logic                  idle,
    input  logic [LVL_W-1:0]      cfg_level,
    input  logic [LVL_W-1:0]      lvl_q,
    input  logic [NUM_LEVELS-1:0] bg_in,
    output logic [NUM_LEVELS-1:0] bg_out
);
    logic [LVL_W-1:0] lvl_eff;

    // While idle the live selection applies; otherwise the latched one.
    assign lvl_eff = idle ? cfg_level : lvl_q;

    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_pass
        assign bg_out[i] = bg_in[i] && (idle || (lvl_eff != LVL_W'(i)));
    end
endmodule

// File: rtl/dtb_requester.sv
module dtb_requester
    import dtb_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LVL_W-1:0]      cfg_level,
    input  logic                  cfg_ror,
    input  logic                  dma_req,
    input  logic                  ds_active,
    input  logic [NUM_LEVELS-1:0] br_in,
    input  logic [NUM_LEVELS-1:0] bg_in,
    output logic [NUM_LEVELS-1:0] br_out,
    output logic [NUM_LEVELS-1:0] bg_out,
    output logic                  bbsy_out,
    output logic                  bus_owned
);
    arb_state_t       state;
    logic [LVL_W-1:0] lvl_q;

    dtb_arb_fsm #(.NUM_LEVELS(NUM_LEVELS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_ror(cfg_ror),
        .dma_req(dma_req), .ds_active(ds_active), .br_in(br_in), .bg_in(bg_in),
        .state(state), .lvl_q(lvl_q)
    );

    dtb_out_decode #(.NUM_LEVELS(NUM_LEVELS)) u_dec (
        .state(state), .lvl_q(lvl_q),
        .br_out(br_out), .bbsy_out(bbsy_out), .bus_owned(bus_owned)
    );

    dtb_grant_chain #(.NUM_LEVELS(NUM_LEVELS)) u_chain (
        .idle(state == ST_IDLE), .cfg_level(cfg_level), .lvl_q(lvl_q),
        .bg_in(bg_in), .bg_out(bg_out)
    );

    assert_br_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(br_out));

    assert_seize_on_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|br_out) && !bbsy_out && (|(bg_in & br_out))) |=> bbsy_out);

    assert_br_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bbsy_out && $past(bbsy_out)) |-> (br_out == '0));

    assert_owned_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_owned |-> (bbsy_out && (br_out == '0)));

    assert_grant_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|br_out) |-> ((bg_out & br_out) == '0));

    assert_keep_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_owned && dma_req && !cfg_ror) |=> bus_owned);

    assert_yield_on_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_owned && cfg_ror && (|br_in)) |=> (!bus_owned && bbsy_out));

    assert_busy_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ds_active) && bbsy_out) |=> bbsy_out);

    assert_level_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|br_out) && $past(|br_out)) |-> $stable(br_out));
endmodule

// File: tb/sim_dtb_requester.sv
`timescale 1ns/1ps
module sim_dtb_requester;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_level;
    logic       cfg_ror;
    logic       dma_req;
    logic       ds_active;
    logic [3:0] br_in;
    logic [3:0] bg_in;
    logic [3:0] br_out;
    logic [3:0] bg_out;
    logic       bbsy_out;
    logic       bus_owned;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dtb_requester u0 (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_ror(cfg_ror),
        .dma_req(dma_req), .ds_active(ds_active), .br_in(br_in), .bg_in(bg_in),
        .br_out(br_out), .bg_out(bg_out), .bbsy_out(bbsy_out), .bus_owned(bus_owned)
    );

    // Reference model: phase 0 idle, 1 asking, 2 seizing, 3 owning, 4 draining, 5 tail.
    int mph = 0;
    int mlvl = 0;
    logic [31:0] rs = 32'h1234_5678;

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, actual, expected);
        end
    endtask

    task automatic compare_all();
        int exp_br, exp_bg, lv;
        exp_br = (mph == 1 || mph == 2) ? (1 << mlvl) : 0;
        lv = (mph == 0) ? int'(cfg_level) : mlvl;
        exp_bg = 0;
        for (int i = 0; i < 4; i++)
            if (bg_in[i] && !(i == lv && mph != 0)) exp_bg |= (1 << i);
        check("R2/R9 br_out", int'(br_out), exp_br);
        check("R3/R8 bbsy_out", int'(bbsy_out), (mph >= 2) ? 1 : 0);
        check("R6/R7 bus_owned", int'(bus_owned), (mph == 3) ? 1 : 0);
        check("R4/R5 bg_out", int'(bg_out), exp_bg);
    endtask

    task automatic model_step();
        unique case (mph)
            0: if (dma_req) begin mph = 1; mlvl = int'(cfg_level); end
            1: if (bg_in[mlvl]) mph = 2;
            2: mph = 3;
            3: if (!dma_req || (cfg_ror && (|br_in))) mph = ds_active ? 4 : 5;
            4: if (!ds_active) mph = 5;
            default: mph = 0;
        endcase
    endtask

    function automatic logic [31:0] nxt(logic [31:0] s);
        logic [31:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    initial begin
        rst_n = 1'b0; cfg_level = 2'd2; cfg_ror = 1'b0; dma_req = 1'b1;
        ds_active = 1'b1; br_in = 4'hF; bg_in = 4'b1110;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state, selected-level grant passes while idle
        check("R1 br_out", int'(br_out), 0);
        check("R1 bbsy_out", int'(bbsy_out), 0);
        check("R1 bus_owned", int'(bus_owned), 0);
        check("R1 bg_out", int'(bg_out), int'(bg_in));
        rst_n = 1'b1; dma_req = 1'b0; ds_active = 1'b0; br_in = '0; bg_in = '0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(posedge clk);
            model_step();
            #5;
            compare_all();
            rs = nxt(rs);
            if (rs[3:0] == 4'd0) dma_req = ~dma_req;
            if (rs[9:5] == 5'd0) cfg_level = rs[11:10];
            if (cyc % 700 == 0) cfg_ror = ~cfg_ror;
            ds_active = rs[12] | rs[13];
            br_in = (rs[15:14] == 2'd0) ? rs[19:16] : 4'h0;
            bg_in = rs[23:20] & rs[27:24];
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule